// File: doc/BRIEF.md
# Compare Output Mode Generator

This block is a single compare channel of a timer. It watches a counter value supplied by the timer and produces two equality events. The channel event fires when the counter equals the channel's compare value. The period event fires when the counter equals the period value. A 3-bit output mode turns these events into actions on one output pin: set, clear, toggle or no action. In up/down counting the channel action also depends on the count direction. One mode bypasses the events and drives the pin from a software bit.

The channel also keeps a compare flag. The flag is set on each channel event and cleared by software. Together with an enable bit it raises an interrupt request. Typical uses are edge-aligned PWM (set/reset in up counting), centre-aligned PWM (toggle/reset in up/down counting) and square waves (toggle).

Top module: `cmp_out_chan`

## Requirements
- R1: With `out_mode` = 000 the pin takes the value of `sw_out` on each clock edge, so it follows one cycle later, and equality events do not change the pin.
- R2: In stop (`cnt_mode` 00), up (01) and free-running (10) counting, a channel event applies the mode's first action: 001 set, 010 toggle, 011 set, 100 toggle, 101 clear, 110 toggle, 111 clear.
- R3: In those count modes a period event applies the mode's second action: 010 clear, 011 clear, 100 toggle, 110 set, 111 set, and no action for 001 and 101.
- R4: When both events occur on the same edge and the period action is not "no action", the period action is applied alone. Otherwise the channel action applies.
- R5: An event is the first edge on which the equality holds. An equality held over several edges acts only once.
- R6: In up/down counting (`cnt_mode` 11) a channel event uses the first action while counting up (`cnt_down` = 0) and the second action while counting down (`cnt_down` = 1). A period event then acts only in mode 100, where it toggles.
- R7: In up counting with mode 011, period P and channel value C < P, the pin is high for P-C of every P+1 ticks.
- R8: In up/down counting with mode 010, period P and channel value 0 < C < P, the pin is high for 2(P-C) of every 2P ticks, and the pulse is centred on the turnaround.
- R9: `cmp_flag` is set on each channel event. It is cleared by `flag_clr`, and a set on the same edge wins. `cmp_irq` is high exactly when the flag and `irq_en` are both high.
- R10: After reset the pin, the flag and the interrupt request are low.
- R11: In mode 100 with the channel value equal to the period in up counting, the pin toggles once per P+1 ticks, which gives a square wave of period 2(P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current timer count |
| cnt_down | input | 1 | 1 while the timer counts down |
| cnt_mode | input | 2 | 00 stop, 01 up, 10 free-running, 11 up/down |
| ccr_val | input | CNT_W | Channel compare value |
| period_val | input | CNT_W | Period value |
| out_mode | input | 3 | Output mode |
| sw_out | input | 1 | Software pin value for mode 000 |
| flag_clr | input | 1 | Clears the compare flag |
| irq_en | input | 1 | Interrupt enable |
| pin_out | output | 1 | Output pin |
| cmp_flag | output | 1 | Compare flag |
| cmp_irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all seven event-driven modes over up, up/down and free-running counting. It uses several channel values, including one equal to the period and one that is never reached, and compares every tick with an arithmetic model. Coincident events in toggle/set and set modes show whether the wrong action wins a tie. A counter held on a match value would toggle the pin repeatedly if the design acted on the equality level and not on its first edge. Duty counts for edge- and centre-aligned PWM expose a reversed direction rule or a swapped first and second action. Flag set-versus-clear collisions and the interrupt gating complete the checks.

// File: rtl/cmp_out_pkg.sv
// Shared types for the compare output channel.
// Assumes: mode and count-mode encodings are fixed by the timer's register layout.
package cmp_out_pkg;

    typedef enum logic [2:0] {
        OM_SWBIT   = 3'b000,
        OM_SET     = 3'b001,
        OM_TOG_CLR = 3'b010,
        OM_SET_CLR = 3'b011,
        OM_TOG     = 3'b100,
        OM_CLR     = 3'b101,
        OM_TOG_SET = 3'b110,
        OM_CLR_SET = 3'b111
    } out_mode_e;

    typedef enum logic [1:0] {
        CM_STOP   = 2'b00,
        CM_UP     = 2'b01,
        CM_FREE   = 2'b10,
        CM_UPDOWN = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TOG  = 2'b11
    } pin_act_e;

    // Returns the action for the first-named part of a mode
    function automatic pin_act_e first_act(input out_mode_e m);
        case (m)
            OM_SET, OM_SET_CLR:              first_act = ACT_SET;
            OM_TOG_CLR, OM_TOG, OM_TOG_SET:  first_act = ACT_TOG;
            OM_CLR, OM_CLR_SET:              first_act = ACT_CLR;
            default:                         first_act = ACT_NONE;
        endcase
    endfunction

    // Returns the action for the second-named part of a mode
    function automatic pin_act_e second_act(input out_mode_e m);
        case (m)
            OM_TOG_CLR, OM_SET_CLR: second_act = ACT_CLR;
            OM_TOG:                 second_act = ACT_TOG;
            OM_TOG_SET, OM_CLR_SET: second_act = ACT_SET;
            default:                second_act = ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cmp_match_edge.sv
// Equality detector with first-edge qualification.
// Compares the counter with one reference value. It reports a rise only on the
// first edge at which the equality holds.
// Assumes: counter and reference are already synchronous to clk.
module cmp_match_edge #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] ref_val,
    output logic             eq_rise
);
    logic eq_now;
    logic eq_q;

    // Combinational equality of counter and reference
    always_comb eq_now = (cnt_val == ref_val);

    // Remembers the previous equality level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_now;
    end

    // Rise is equality now that was absent on the previous edge
    always_comb eq_rise = eq_now & ~eq_q;

    // A held equality must never produce a second rise
    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        eq_rise && (cnt_val == ref_val) |=> !eq_rise || !$stable(ref_val) || !$stable(cnt_val) || 1'b1 && !eq_rise); // R5

endmodule

// File: rtl/cmp_action_sel.sv
// Maps output mode, count mode and direction to the action each event takes.
// Assumes: mode 000 is handled by the pin driver and needs no action here.
module cmp_action_sel
    import cmp_out_pkg::*;
(
    input  out_mode_e mode,
    input  cnt_mode_e cmode,
    input  logic      cnt_down,
    output pin_act_e  ch_act,
    output pin_act_e  per_act
);
    logic updown;

    // Flags the symmetric counting mode
    always_comb updown = (cmode == CM_UPDOWN);

    // Selects the channel-event action, direction-dependent in up/down counting
    always_comb begin
        if (updown && cnt_down) ch_act = second_act(mode);
        else                    ch_act = first_act(mode);
    end

    // Selects the period-event action; only toggle acts on it in up/down counting
    always_comb begin
        if (updown) per_act = (mode == OM_TOG) ? ACT_TOG : ACT_NONE;
        else        per_act = second_act(mode);
    end

endmodule

// File: rtl/cmp_pin_drive.sv
// Output pin register.
// Applies the winning event action to the pin, or copies the software bit in
// mode 000. When both events coincide, a period action other than "none" wins.
// Assumes: event rises are single-cycle pulses from cmp_match_edge.
module cmp_pin_drive
    import cmp_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  logic      sw_out,
    input  logic      ch_rise,
    input  logic      per_rise,
    input  pin_act_e  ch_act,
    input  pin_act_e  per_act,
    output logic      pin
);
    pin_act_e sel_act;
    logic     pin_nxt;

    // Resolves which event's action applies on this edge
    always_comb begin
        if (per_rise && (per_act != ACT_NONE)) sel_act = per_act;
        else if (ch_rise)                      sel_act = ch_act;
        else                                   sel_act = ACT_NONE;
    end

    // Computes the next pin level from the resolved action
    always_comb begin
        if (mode == OM_SWBIT) begin
            pin_nxt = sw_out;
        end else begin
            case (sel_act)
                ACT_SET: pin_nxt = 1'b1;
                ACT_CLR: pin_nxt = 1'b0;
                ACT_TOG: pin_nxt = ~pin;
                default: pin_nxt = pin;
            endcase
        end
    end

    // Holds the pin level
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_nxt;
    end

    AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_SWBIT) |=> (pin == $past(sw_out))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != OM_SWBIT) && !ch_rise && !per_rise |=> $stable(pin)); // R5
    AST_TIE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != OM_SWBIT) && ch_rise && per_rise && (per_act == ACT_SET) |=> pin); // R4

endmodule

// File: rtl/cmp_flag_ctl.sv
// Compare flag and interrupt request.
// The flag is set by a channel event and cleared by software; set wins.
// Assumes: flag_clr is a synchronous single-cycle request.
module cmp_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_rise,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Updates the flag with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (ch_rise)  flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Gates the interrupt request with the enable
    always_comb irq = flag & irq_en;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ch_rise |=> flag); // R9
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !ch_rise |=> !flag); // R9
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr && !ch_rise |=> $stable(flag)); // R9

endmodule

// File: rtl/cmp_out_chan.sv
// Compare output channel top.
// Builds the two equality events (channel and period), selects their actions
// from the output and count modes, and drives the pin and the compare flag.
// Assumes: the timer supplies count, direction and mode on the same clock.
module cmp_out_chan
    import cmp_out_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] ccr_val,
    input  logic [CNT_W-1:0] period_val,
    input  logic [2:0]       out_mode,
    input  logic             sw_out,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             pin_out,
    output logic             cmp_flag,
    output logic             cmp_irq
);
    localparam int NUM_EV = 2;
    localparam int EV_CH  = 0;
    localparam int EV_PER = 1;

    out_mode_e        mode;
    cnt_mode_e        cmode;
    logic [CNT_W-1:0] ref_vals [NUM_EV];
    logic [NUM_EV-1:0] ev_rise;
    pin_act_e         ch_act;
    pin_act_e         per_act;

    // Casts raw port encodings to the shared types
    always_comb begin
        mode  = out_mode_e'(out_mode);
        cmode = cnt_mode_e'(cnt_mode);
    end

    // Orders the reference values by event index
    always_comb begin
        ref_vals[EV_CH]  = ccr_val;
        ref_vals[EV_PER] = period_val;
    end

    // One equality detector per event
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        cmp_match_edge #(.CNT_W(CNT_W)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_val (cnt_val),
            .ref_val (ref_vals[i]),
            .eq_rise (ev_rise[i])
        );
    end

    cmp_action_sel u_sel (
        .mode     (mode),
        .cmode    (cmode),
        .cnt_down (cnt_down),
        .ch_act   (ch_act),
        .per_act  (per_act)
    );

    cmp_pin_drive u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .sw_out   (sw_out),
        .ch_rise  (ev_rise[EV_CH]),
        .per_rise (ev_rise[EV_PER]),
        .ch_act   (ch_act),
        .per_act  (per_act),
        .pin      (pin_out)
    );

    cmp_flag_ctl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_rise  (ev_rise[EV_CH]),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .flag     (cmp_flag),
        .irq      (cmp_irq)
    );

    AST_UD_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode == CM_UPDOWN) && (mode != OM_TOG) && (mode != OM_SWBIT)
        && ev_rise[EV_PER] && !ev_rise[EV_CH] |=> $stable(pin_out)); // R6
    AST_UD_DOWN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode == CM_UPDOWN) && cnt_down && (mode == OM_SET_CLR)
        && ev_rise[EV_CH] && !ev_rise[EV_PER] |=> !pin_out); // R6
    AST_UP_CH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode != CM_UPDOWN) && (mode == OM_SET) && ev_rise[EV_CH] |=> pin_out); // R2
    AST_UP_PER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode != CM_UPDOWN) && (mode == OM_SET_CLR) && ev_rise[EV_PER] |=> !pin_out); // R3
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !pin_out && !cmp_flag); // R10

endmodule

// File: tb/cmp_out_chan_tb.sv
`timescale 1ns/1ps
module cmp_out_chan_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         dir_down = 1'b0;
    logic [1:0]   cm = 2'b01;
    logic [W-1:0] ccr = '0;
    logic [W-1:0] per = '0;
    logic [2:0]   mode = 3'b000;
    logic         sw = 1'b0;
    logic         clr = 1'b0;
    logic         ien = 1'b0;
    logic         pin, flag, irq;

    int nchk = 0;
    int nfail = 0;

    // model state
    logic m_pin = 1'b0, m_flag = 1'b0, m_pch = 1'b0, m_pper = 1'b0;

    always #2.5 clk = ~clk;

    cmp_out_chan #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cnt_down(dir_down),
        .cnt_mode(cm), .ccr_val(ccr), .period_val(per), .out_mode(mode),
        .sw_out(sw), .flag_clr(clr), .irq_en(ien),
        .pin_out(pin), .cmp_flag(flag), .cmp_irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // action codes: 0 none, 1 set, 2 clear, 3 toggle
    function automatic int act_first(input logic [2:0] m);
        case (m)
            3'd1, 3'd3:       return 1;
            3'd2, 3'd4, 3'd6: return 3;
            3'd5, 3'd7:       return 2;
            default:          return 0;
        endcase
    endfunction

    function automatic int act_second(input logic [2:0] m);
        case (m)
            3'd2, 3'd3: return 2;
            3'd4:       return 3;
            3'd6, 3'd7: return 1;
            default:    return 0;
        endcase
    endfunction

    function automatic logic apply(input int a, input logic p);
        case (a)
            1:       return 1'b1;
            2:       return 1'b0;
            3:       return ~p;
            default: return p;
        endcase
    endfunction

    task automatic model_step();
        logic ce, pe, cr, pr;
        int ach, apr;
        if (!rst_n) begin
            m_pin = 0; m_flag = 0; m_pch = 0; m_pper = 0;
        end else begin
            ce = (cnt == ccr); pe = (cnt == per);
            cr = ce && !m_pch; pr = pe && !m_pper;
            m_pch = ce; m_pper = pe;
            if (cr) m_flag = 1'b1;
            else if (clr) m_flag = 1'b0;
            if (mode == 3'd0) m_pin = sw;
            else begin
                ach = (cm == 2'b11 && dir_down) ? act_second(mode) : act_first(mode);
                apr = (cm == 2'b11) ? ((mode == 3'd4) ? 3 : 0) : act_second(mode);
                if (pr && apr != 0) m_pin = apply(apr, m_pin);
                else if (cr)        m_pin = apply(ach, m_pin);
            end
        end
    endtask

    task automatic tick(input logic [W-1:0] c, input logic d, input string tag);
        cnt = c; dir_down = d;
        @(posedge clk); #1;
        model_step();
        chk(pin == m_pin, {tag, " pin"}, pin, m_pin);
        chk(flag == m_flag, {tag, " flag"}, flag, m_flag);
    endtask

    task automatic run_up(input int p, input int n, input string tag);
        for (int k = 0; k < n; k++)
            for (int v = 0; v <= p; v++) tick(v[W-1:0], 1'b0, tag);
    endtask

    task automatic run_ud(input int p, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            for (int v = 0; v <= p; v++) tick(v[W-1:0], 1'b0, tag);
            for (int v = p - 1; v >= 1; v--) tick(v[W-1:0], 1'b1, tag);
        end
    endtask

    task automatic force_pin(input logic val);
        logic [2:0] keep;
        keep = mode; mode = 3'd0; sw = val;
        tick(cnt, dir_down, "R1");
        mode = keep;
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        int hi, tr;
        logic prev;
        // R10: reset state
        rst_n = 0;
        tick(0, 0, "R10"); tick(0, 0, "R10");
        chk(pin == 0 && flag == 0 && irq == 0, "R10 reset outputs", {pin, flag, irq}, 0);
        rst_n = 1;

        // R1: software bit drives pin, events ignored
        mode = 3'd0; ccr = 3; per = 5; cm = 2'b01;
        for (int i = 0; i < 24; i++) begin
            sw = (i % 3 == 1);
            prev = sw;
            tick(i % 6, 0, "R1");
            chk(pin == prev, "R1 software follow", pin, prev);
        end

        // R2 R3 R6: sweep of modes, count modes and channel values
        per = 6;
        for (int m = 1; m < 8; m++) begin
            for (int cv = 0; cv < 4; cv++) begin
                ccr = (cv == 0) ? 0 : (cv == 1) ? 3 : (cv == 2) ? 6 : 9;
                mode = m[2:0];
                cm = 2'b01; force_pin(0); run_up(6, 3, "R2 R3 up");
                cm = 2'b11; force_pin(0); run_ud(6, 3, "R6 updown");
                cm = 2'b10; force_pin(1);
                for (int v = 0; v < 256; v++) tick(v[W-1:0], 1'b0, "R2 R3 free");
            end
        end

        // R4: coincident events, period set beats channel toggle
        cm = 2'b01; mode = 3'd6; ccr = 5; per = 5;
        force_pin(1); tick(0, 0, "R4"); tick(5, 0, "R4");
        chk(pin == 1, "R4 period action wins", pin, 1);
        // R4: period action none, channel set applies
        mode = 3'd1; force_pin(0); tick(0, 0, "R4"); tick(5, 0, "R4");
        chk(pin == 1, "R4 channel applies when period none", pin, 1);

        // R5: held equality in stop mode toggles once
        cm = 2'b00; mode = 3'd4; ccr = 9; per = 20;
        force_pin(0); tick(0, 0, "R5");
        for (int i = 0; i < 6; i++) tick(9, 0, "R5");
        chk(pin == 1, "R5 single toggle on held match", pin, 1);

        // R6: set on upward match, clear on downward match
        cm = 2'b11; mode = 3'd3; ccr = 2; per = 7;
        force_pin(0); tick(0, 0, "R6"); tick(1, 0, "R6"); tick(2, 0, "R6");
        chk(pin == 1, "R6 up match set", pin, 1);
        tick(1, 1, "R6"); tick(2, 1, "R6");
        chk(pin == 0, "R6 down match clear", pin, 0);

        // R7: edge-aligned PWM duty
        cm = 2'b01; mode = 3'd3; ccr = 5; per = 8;
        force_pin(0); run_up(8, 1, "R7");
        hi = 0;
        for (int v = 0; v <= 8; v++) begin tick(v[W-1:0], 0, "R7"); hi += pin; end
        chk(hi == 3, "R7 edge-aligned high ticks", hi, 3);

        // R8: centre-aligned PWM duty and symmetry
        cm = 2'b11; mode = 3'd2; ccr = 4; per = 7;
        force_pin(0); run_ud(7, 1, "R8");
        hi = 0;
        for (int v = 0; v <= 7; v++) begin tick(v[W-1:0], 0, "R8"); hi += pin; end
        chk(pin == 1, "R8 high at top", pin, 1);
        for (int v = 6; v >= 1; v--) begin tick(v[W-1:0], 1, "R8"); hi += pin; end
        chk(hi == 6, "R8 centre-aligned high ticks", hi, 6);

        // R11: toggle with channel equal to period gives square wave
        cm = 2'b01; mode = 3'd4; ccr = 5; per = 5;
        force_pin(0); run_up(5, 1, "R11");
        tr = 0; prev = pin;
        for (int k = 0; k < 4; k++)
            for (int v = 0; v <= 5; v++) begin
                tick(v[W-1:0], 0, "R11");
                if (pin != prev) tr++;
                prev = pin;
            end
        chk(tr == 4, "R11 one toggle per wrap", tr, 4);

        // R9: flag, clear, priority and interrupt gating
        mode = 3'd1; ccr = 3; per = 50; ien = 0;
        tick(0, 0, "R9"); clr = 1; tick(1, 0, "R9"); clr = 0;
        chk(flag == 0, "R9 flag cleared", flag, 0);
        tick(3, 0, "R9");
        chk(flag == 1, "R9 flag set on match", flag, 1);
        chk(irq == 0, "R9 irq masked", irq, 0);
        ien = 1; #1;
        chk(irq == 1, "R9 irq enabled", irq, 1);
        tick(4, 0, "R9"); clr = 1; tick(3, 0, "R9"); clr = 0;
        chk(flag == 1, "R9 set beats clear", flag, 1);
        clr = 1; tick(4, 0, "R9"); clr = 0;
        chk(flag == 0 && irq == 0, "R9 clear drops irq", {flag, irq}, 0);

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule